// File: doc/BRIEF.md
# Segment Descriptor Load Sequencer

This block runs whenever a new 16-bit selector is written into a segment register. It splits the selector into a table index, a table choice and a requested privilege level. It screens out the null selector and any index beyond the selected table's limit. It then fetches the 8-byte descriptor as two 32-bit reads over a simple memory port with a ready handshake. The base and limit, which the descriptor stores in scattered pieces, are put back together. The sequencer then checks presence and privilege. On success it fills the descriptor cache entry and pulses `done`. On failure it pulses `fault` and presents a fault code, and the cached entry stays as it was.

If the accessed flag in the fetched descriptor is clear, the sequencer writes the upper descriptor word back with that flag set before it reports completion. Two table registers supply the table locations: one for the global table and one for the local table, each with a 32-bit base and a 16-bit byte limit.

Top module: `seg_desc_loader`

## Requirements
- R1: Selector bit 2 picks the table: 0 selects the global table, 1 selects the local table. The low descriptor word is read at table base + (selector bits 15:3 × 8). The high word is read at that address + 4.
- R2: A selector whose bit 2 is 0 and whose bits 15:3 are all zero is null. It ends in a fault with code 1, whatever its bits 1:0 hold, and no memory access is made. The null test comes before the table-limit test.
- R3: When (selector bits 15:3 × 8) + 7 is greater than the selected table's limit, the load ends in a fault with code 2 and no memory access is made. An entry whose last byte equals the limit is accepted.
- R4: When the present flag (bit 7 of the access byte) is 0, the load ends in a fault with code 3.
- R5: When the selector's bits 1:0, read as a number, are greater than the descriptor privilege level (access-byte bits 6:5), the load ends in a fault with code 4. Descriptors whose type field (access-byte bits 3:1) is 6 or 7 are exempt from this check.
- R6: The cached base is high-word bits 31:24, then high-word bits 7:0, then low-word bits 31:16. The 20-bit raw limit is high-word bits 19:16 followed by low-word bits 15:0. The flag nibble is high-word bits 23:20. When its top bit is 1, the cached limit is the raw limit shifted left by 12 with the low 12 bits filled with ones; otherwise it is the raw limit zero-extended. The access byte is high-word bits 15:8.
- R7: When the fetched access byte has bit 0 clear, exactly one write goes to the high-word address before `done`. The data is the fetched high word with bit 8 set. When bit 0 is already set, no write is made. The cached access byte always has bit 0 set.
- R8: The cache entry (valid flag, selector, base, limit, access byte, flags) changes only when a load succeeds. A fault leaves it unchanged.
- R9: A memory request holds its address, direction and data until the cycle in which `mem_ready` is high. Each such cycle completes exactly one access.
- R10: Each load ends in exactly one single-cycle pulse of either `done` or `fault`, never both. A `load_req` that arrives while `busy` is high is ignored. Fault codes: 0 none, 1 null, 2 table limit, 3 not present, 4 privilege.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Start a load with `load_sel` (taken only when idle) |
| load_sel | input | 16 | Selector being loaded |
| gtab_base | input | 32 | Global table base address |
| gtab_limit | input | 16 | Global table byte limit |
| ltab_base | input | 32 | Local table base address |
| ltab_limit | input | 16 | Local table byte limit |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse: load succeeded |
| fault | output | 1 | One-cycle pulse: load rejected |
| fault_code | output | 3 | Code of the last fault |
| cache_valid | output | 1 | Cache entry holds a loaded descriptor |
| cache_sel | output | 16 | Selector of the cached entry |
| cache_base | output | 32 | Cached segment base |
| cache_limit | output | 32 | Cached byte limit after granularity expansion |
| cache_rights | output | 8 | Cached access byte (accessed bit set) |
| cache_flags | output | 4 | Cached flag nibble |

## Verification
Several properties are checked on every cycle. Requests stay stable until ready arrives. `done` and `fault` are exclusive single-cycle pulses. Write-back data always carries the accessed bit. A successful load always shows a present descriptor, an allowed privilege and a set accessed bit. The cache never moves except together with `done`. Null and limit faults are checked to follow a cycle with no memory request. Correct address formation, the reassembled base and limit values, the exact count of reads and writes, the write-back address and contents, and `load_req` being ignored while busy can be shown only by the bench's scenarios against its memory model.

// File: rtl/seg_ld_pkg.sv
package seg_ld_pkg;

    localparam int SEL_W    = 16;
    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 32;
    localparam int TLIM_W   = 16;
    localparam int IDX_W    = SEL_W - 3;
    localparam int RAWLIM_W = 20;
    localparam int PAGE_SH  = ADDR_W - RAWLIM_W;
    localparam int ACC_POS  = 8;   // accessed flag inside the high word
    localparam logic [WORD_W-1:0] ACC_MASK = WORD_W'(1) << ACC_POS;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_NULL   = 3'd1,
        FLT_TLIM   = 3'd2,
        FLT_ABSENT = 3'd3,
        FLT_PRIV   = 3'd4
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_RD_LO, S_RD_HI, S_VALIDATE, S_WB_ACC, S_DONE, S_FAULT
    } ld_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             ti;
        logic [1:0]       rpl;
    } sel_t;

    typedef struct packed {
        logic       present;
        logic [1:0] dpl;
        logic       s;
        logic [2:0] kind;
        logic       accessed;
    } rights_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        rights_t           rights;
        logic [3:0]        flags;
    } desc_t;

    function automatic logic is_conforming(logic [2:0] kind);
        return (kind | 3'b001) == 3'b111;
    endfunction

    function automatic logic [ADDR_W-1:0] expand_limit(logic [RAWLIM_W-1:0] raw, logic gran);
        if (gran)
            return {raw, {PAGE_SH{1'b1}}};
        return {{PAGE_SH{1'b0}}, raw};
    endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_ld_pkg::*;
(
    input  logic [IDX_W-1:0]  index,
    input  logic              ti,
    input  logic [ADDR_W-1:0] gbase,
    input  logic [TLIM_W-1:0] glimit,
    input  logic [ADDR_W-1:0] lbase,
    input  logic [TLIM_W-1:0] llimit,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              is_null,
    output logic              over_limit
);
    logic [TLIM_W-1:0] offset;
    logic [TLIM_W:0]   last_byte;
    logic [TLIM_W-1:0] tab_lim;

    always_comb begin
        offset     = {index, 3'b000};
        last_byte  = {1'b0, offset} + (TLIM_W+1)'(7);
        tab_lim    = ti ? llimit : glimit;
        over_limit = last_byte > {1'b0, tab_lim};
        is_null    = !ti && (index == '0);
        desc_addr  = (ti ? lbase : gbase) + ADDR_W'(offset);
    end
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_ld_pkg::*;
(
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    output desc_t             desc
);
    logic [RAWLIM_W-1:0] raw_lim;

    always_comb begin
        raw_lim     = {hi_word[19:16], lo_word[15:0]};
        desc.base   = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
        desc.rights = rights_t'(hi_word[15:8]);
        desc.flags  = hi_word[23:20];
        desc.limit  = expand_limit(raw_lim, hi_word[23]);
    end
endmodule

// File: rtl/seg_desc_rules.sv
module seg_desc_rules
    import seg_ld_pkg::*;
(
    input  logic       present,
    input  logic [1:0] dpl,
    input  logic [2:0] kind,
    input  logic       accessed,
    input  logic [1:0] rpl,
    output fault_e     verdict,
    output logic       need_wb
);
    always_comb begin
        if (!present)
            verdict = FLT_ABSENT;
        else if ((rpl > dpl) && !is_conforming(kind))
            verdict = FLT_PRIV;
        else
            verdict = FLT_NONE;
        need_wb = !accessed;
    end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
    import seg_ld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic [SEL_W-1:0]  load_sel,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [TLIM_W-1:0] gtab_limit,
    input  logic [ADDR_W-1:0] ltab_base,
    input  logic [TLIM_W-1:0] ltab_limit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [2:0]        fault_code,
    output logic              cache_valid,
    output logic [SEL_W-1:0]  cache_sel,
    output logic [ADDR_W-1:0] cache_base,
    output logic [ADDR_W-1:0] cache_limit,
    output logic [7:0]        cache_rights,
    output logic [3:0]        cache_flags
);
    ld_state_e         state, nxt;
    sel_t              sel_q;
    logic [WORD_W-1:0] lo_q, hi_q;
    fault_e            flt_q;

    logic [ADDR_W-1:0] desc_addr;
    logic              sel_null, sel_over;
    desc_t             dsc;
    fault_e            verdict;
    logic              need_wb;
    rights_t           rights_set;

    seg_sel_decode u_dec (
        .index      (sel_q.index),
        .ti         (sel_q.ti),
        .gbase      (gtab_base),
        .glimit     (gtab_limit),
        .lbase      (ltab_base),
        .llimit     (ltab_limit),
        .desc_addr  (desc_addr),
        .is_null    (sel_null),
        .over_limit (sel_over)
    );

    seg_desc_unpack u_unp (
        .lo_word (lo_q),
        .hi_word (hi_q),
        .desc    (dsc)
    );

    seg_desc_rules u_rules (
        .present  (dsc.rights.present),
        .dpl      (dsc.rights.dpl),
        .kind     (dsc.rights.kind),
        .accessed (dsc.rights.accessed),
        .rpl      (sel_q.rpl),
        .verdict  (verdict),
        .need_wb  (need_wb)
    );

    always_comb begin
        rights_set          = dsc.rights;
        rights_set.accessed = 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (load_req) nxt = S_CHECK;
            S_CHECK:    nxt = (sel_null || sel_over) ? S_FAULT : S_RD_LO;
            S_RD_LO:    if (mem_ready) nxt = S_RD_HI;
            S_RD_HI:    if (mem_ready) nxt = S_VALIDATE;
            S_VALIDATE: begin
                if (verdict != FLT_NONE) nxt = S_FAULT;
                else if (need_wb)        nxt = S_WB_ACC;
                else                     nxt = S_DONE;
            end
            S_WB_ACC:   if (mem_ready) nxt = S_DONE;
            S_DONE:     nxt = S_IDLE;
            S_FAULT:    nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            sel_q        <= '0;
            lo_q         <= '0;
            hi_q         <= '0;
            flt_q        <= FLT_NONE;
            cache_valid  <= 1'b0;
            cache_sel    <= '0;
            cache_base   <= '0;
            cache_limit  <= '0;
            cache_rights <= '0;
            cache_flags  <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && load_req)
                sel_q <= sel_t'(load_sel);
            if (state == S_RD_LO && mem_ready)
                lo_q <= mem_rdata;
            if (state == S_RD_HI && mem_ready)
                hi_q <= mem_rdata;
            if (state == S_CHECK && nxt == S_FAULT)
                flt_q <= sel_null ? FLT_NULL : FLT_TLIM;
            else if (state == S_VALIDATE && nxt == S_FAULT)
                flt_q <= verdict;
            if (nxt == S_DONE && state != S_DONE) begin
                cache_valid  <= 1'b1;
                cache_sel    <= sel_q;
                cache_base   <= dsc.base;
                cache_limit  <= dsc.limit;
                cache_rights <= rights_set;
                cache_flags  <= dsc.flags;
            end
        end
    end

    always_comb begin
        mem_req    = (state == S_RD_LO) || (state == S_RD_HI) || (state == S_WB_ACC);
        mem_we     = (state == S_WB_ACC);
        mem_addr   = (state == S_RD_LO) ? desc_addr : desc_addr + ADDR_W'(4);
        mem_wdata  = hi_q | ACC_MASK;
        busy       = (state != S_IDLE);
        done       = (state == S_DONE);
        fault      = (state == S_FAULT);
        fault_code = flt_q;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10
    end_excl_chk: assert property (@(posedge clk) disable iff (rst) !(done && fault));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R8
    cache_move_chk: assert property (@(posedge clk) disable iff (rst)
        ((cache_sel != $past(cache_sel)) || (cache_base != $past(cache_base)) ||
         (cache_limit != $past(cache_limit)) || (cache_rights != $past(cache_rights)) ||
         (cache_valid != $past(cache_valid))) |-> done);

    // R4
    present_chk: assert property (@(posedge clk) disable iff (rst) done |-> cache_rights[7]);

    // R5
    priv_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((cache_sel[1:0] <= cache_rights[6:5]) || (cache_rights[3:2] == 2'b11)));

    // R7
    wb_data_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[ACC_POS]);

    // R7
    acc_cached_chk: assert property (@(posedge clk) disable iff (rst) done |-> cache_rights[0]);

    // R2 R3
    early_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && (fault_code == FLT_NULL || fault_code == FLT_TLIM)) |-> !$past(mem_req));
endmodule

// File: tb/seg_desc_loader_test.sv
`timescale 1ns/1ps
module seg_desc_loader_test;
    import seg_ld_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_req = 1'b0;
    logic [15:0] load_sel = '0;
    logic [31:0] gtab_base = 32'h0000_0000;
    logic [15:0] gtab_limit = 16'h003F;
    logic [31:0] ltab_base = 32'h0000_0040;
    logic [15:0] ltab_limit = 16'h0017;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        busy, done, fault, cache_valid;
    logic [2:0]  fault_code;
    logic [15:0] cache_sel;
    logic [31:0] cache_base, cache_limit;
    logic [7:0]  cache_rights;
    logic [3:0]  cache_flags;

    always #4 clk = ~clk;

    seg_desc_loader uut (
        .clk(clk), .rst(rst), .load_req(load_req), .load_sel(load_sel),
        .gtab_base(gtab_base), .gtab_limit(gtab_limit),
        .ltab_base(ltab_base), .ltab_limit(ltab_limit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
        .cache_valid(cache_valid), .cache_sel(cache_sel), .cache_base(cache_base),
        .cache_limit(cache_limit), .cache_rights(cache_rights), .cache_flags(cache_flags)
    );

    typedef struct {
        bit          is_fault;
        logic [2:0]  code;
        logic        valid;
        logic [15:0] sel;
        logic [31:0] base;
        logic [31:0] limit;
        logic [7:0]  rights;
        logic [3:0]  flags;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] mem [64];
    int          lat = 0;
    int          n_rd = 0, n_wr = 0;
    logic [31:0] last_wr_addr = '0, last_rd_addr = '0;
    int          checks = 0, errors = 0;
    bit          finished = 0;

    logic        m_valid = 0;
    logic [15:0] m_sel = '0;
    logic [31:0] m_base = '0, m_limit = '0;
    logic [7:0]  m_rights = '0;
    logic [3:0]  m_flags = '0;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(logic [31:0] base, logic [19:0] lim, logic [7:0] rights, logic [3:0] flags);
        logic [31:0] lo, hi;
        lo = {base[15:0], lim[15:0]};
        hi = {base[31:24], flags, lim[19:16], rights, base[23:16]};
        return {hi, lo};
    endfunction

    task automatic put(int addr, logic [63:0] d);
        mem[addr >> 2]       = d[31:0];
        mem[(addr >> 2) + 1] = d[63:32];
    endtask

    // memory responder
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt >= lat) begin
                    mem_ready = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr[7:2]] = mem_wdata;
                        n_wr++;
                        last_wr_addr = mem_addr;
                    end else begin
                        mem_rdata = mem[mem_addr[7:2]];
                        n_rd++;
                        last_rd_addr = mem_addr;
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (done || fault)) begin
                chk(!(done && fault), "R10", "done and fault together", {done, fault}, 2'b00);
                if (sb_q.size() == 0) begin
                    chk(0, "R10", "completion without a request", {done, fault}, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(fault == e.is_fault, e.tag, "fault flag", fault, e.is_fault);
                    if (e.is_fault)
                        chk(fault_code == e.code, e.tag, "fault code", fault_code, e.code);
                    chk(cache_valid == e.valid, e.tag, "cache valid", cache_valid, e.valid);
                    chk(cache_sel == e.sel, e.tag, "cache selector", cache_sel, e.sel);
                    chk(cache_base == e.base, e.tag, "cache base", cache_base, e.base);
                    chk(cache_limit == e.limit, e.tag, "cache limit", cache_limit, e.limit);
                    chk(cache_rights == e.rights, e.tag, "cache rights", cache_rights, e.rights);
                    chk(cache_flags == e.flags, e.tag, "cache flags", cache_flags, e.flags);
                end
            end
        end
    end

    task automatic pulse(logic [15:0] sel);
        @(negedge clk);
        load_sel = sel;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || sb_q.size() != 0);
    endtask

    task automatic push_model(bit is_f, logic [2:0] code, string tag);
        exp_t e;
        e.is_fault = is_f; e.code = code; e.valid = m_valid; e.sel = m_sel;
        e.base = m_base; e.limit = m_limit; e.rights = m_rights; e.flags = m_flags;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic load_ok(logic [15:0] sel, logic [31:0] base, logic [19:0] lim,
                           logic [7:0] rights, logic [3:0] flags, string tag);
        m_valid  = 1'b1;
        m_sel    = sel;
        m_base   = base;
        m_limit  = flags[3] ? {lim, 12'hFFF} : {12'h000, lim};
        m_rights = rights | 8'h01;
        m_flags  = flags;
        push_model(0, 3'd0, tag);
        pulse(sel);
        wait_idle();
    endtask

    task automatic load_bad(logic [15:0] sel, logic [2:0] code, string tag);
        push_model(1, code, tag);
        pulse(sel);
        wait_idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int rd0, wr0;
        for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | i;
        put(32'h08, mk(32'h1234_5678, 20'hABCDE, 8'h92, 4'h4));
        put(32'h10, mk(32'hCAFE_0000, 20'h00FFF, 8'h93, 4'hC));
        put(32'h18, mk(32'h0000_1000, 20'h00100, 8'h12, 4'h0));
        put(32'h20, mk(32'h0BAD_F00D, 20'h00200, 8'h92, 4'h0));
        put(32'h28, mk(32'h0002_0000, 20'h0FFFF, 8'h9D, 4'h4));
        put(32'h30, mk(32'h0003_0000, 20'h00300, 8'hF3, 4'h0));
        put(32'h38, mk(32'h0000_7000, 20'h00010, 8'h93, 4'h0));
        put(32'h40, mk(32'h00AB_0000, 20'h12345, 8'h93, 4'h0));
        put(32'h50, mk(32'h0000_0001, 20'h00002, 8'h92, 4'h0));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fault, "R10", "reset outputs", {busy, done, fault}, 0);
        chk(!cache_valid && !mem_req, "R8", "reset cache/mem", {cache_valid, mem_req}, 0);
        chk(fault_code == 3'd0, "R10", "reset fault code", fault_code, 0);

        // R1 R6 R7: global entry 1, accessed clear
        rd0 = n_rd; wr0 = n_wr;
        load_ok(16'h0008, 32'h1234_5678, 20'hABCDE, 8'h92, 4'h4, "R6");
        chk(n_rd - rd0 == 2, "R9", "reads per load", n_rd - rd0, 2);
        chk(last_rd_addr == 32'h0C, "R1", "high word address", last_rd_addr, 32'h0C);
        chk(n_wr - wr0 == 1, "R7", "write-back count", n_wr - wr0, 1);
        chk(last_wr_addr == 32'h0C, "R7", "write-back address", last_wr_addr, 32'h0C);
        chk(mem[3] == (mk(32'h1234_5678, 20'hABCDE, 8'h93, 4'h4) >> 32), "R7",
            "write-back data", mem[3], mk(32'h1234_5678, 20'hABCDE, 8'h93, 4'h4) >> 32);

        // R7: reload, accessed now set -> no write
        wr0 = n_wr;
        load_ok(16'h0008, 32'h1234_5678, 20'hABCDE, 8'h93, 4'h4, "R7");
        chk(n_wr == wr0, "R7", "no write when accessed", n_wr - wr0, 0);

        // R6: page granularity
        load_ok(16'h0010, 32'hCAFE_0000, 20'h00FFF, 8'h93, 4'hC, "R6");

        // R2: null selectors, no memory traffic, cache kept (R8)
        rd0 = n_rd;
        load_bad(16'h0000, 3'd1, "R2");
        load_bad(16'h0003, 3'd1, "R2");
        chk(n_rd == rd0, "R2", "no read on null", n_rd - rd0, 0);
        gtab_limit = 16'h0000;
        load_bad(16'h0000, 3'd1, "R2");
        gtab_limit = 16'h003F;

        // R1 R9: local table with wait states
        lat = 3;
        rd0 = n_rd;
        load_ok(16'h0004, 32'h00AB_0000, 20'h12345, 8'h93, 4'h0, "R1");
        chk(n_rd - rd0 == 2, "R9", "reads with wait states", n_rd - rd0, 2);
        wr0 = n_wr;
        load_ok(16'h0014, 32'h0000_0001, 20'h00002, 8'h92, 4'h0, "R3");
        chk(last_wr_addr == 32'h54, "R1", "local write-back address", last_wr_addr, 32'h54);
        chk(n_wr - wr0 == 1, "R7", "local write-back count", n_wr - wr0, 1);

        // R3: table limit
        rd0 = n_rd;
        load_bad(16'h001C, 3'd2, "R3");
        load_bad(16'h0040, 3'd2, "R3");
        chk(n_rd == rd0, "R3", "no read on limit fault", n_rd - rd0, 0);
        load_ok(16'h0038, 32'h0000_7000, 20'h00010, 8'h93, 4'h0, "R3");

        // R4, R5
        load_bad(16'h0018, 3'd3, "R4");
        load_bad(16'h0023, 3'd4, "R5");
        load_ok(16'h0020, 32'h0BAD_F00D, 20'h00200, 8'h92, 4'h0, "R5");
        load_ok(16'h002B, 32'h0002_0000, 20'h0FFFF, 8'h9D, 4'h4, "R5");
        load_ok(16'h0033, 32'h0003_0000, 20'h00300, 8'hF3, 4'h0, "R5");

        // R10: request while busy is ignored
        m_valid = 1'b1; m_sel = 16'h0038; m_base = 32'h0000_7000; m_limit = 32'h10;
        m_rights = 8'h93; m_flags = 4'h0;
        push_model(0, 3'd0, "R10");
        pulse(16'h0038);
        @(negedge clk);
        load_sel = 16'h0010;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk(!busy, "R10", "idle after ignored request", busy, 0);
        chk(cache_sel == 16'h0038, "R10", "ignored selector not loaded", cache_sel, 16'h0038);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule